// File: doc/BRIEF.md
# Segmented Operand Address Generator

This block turns the address description of one memory operand into the two addresses a segmented processor needs. The operand offset is formed from up to three terms: a base register value, an index register value shifted by a scale of 1, 2, 4 or 8, and a displacement. The linear address is that offset added to the base address of the selected segment. The decoder supplies a mode descriptor that says which terms are present, the two register values, the displacement field, the size-control bits and the segment's base and limit. The block returns the offset, the linear address, a flag for an illegal register or form choice, and a protection fault flag.

The address width used for an operand follows the code segment's default-size bit, or the narrow width when the core is in real mode. A per-operand override flag inverts that width. In narrow mode only the classic pairings of base and index are legal, there is no scaling, and the sum wraps at 16 bits. A request that uses both base and index holds the requester off for one extra cycle. Every other form returns its result on the cycle after acceptance.

Top module: `seg_ea_gen`

## Requirements
- R1: The offset is base + (index << scale) + extended displacement modulo 2^32 when the width is wide. An absent base, absent index or absent displacement adds zero. A request without both base and index raises `out_valid` on the clock after it is accepted (`req_valid` and `req_ready` both high).
- R2: The scale code values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8. The scale acts only on the index term.
- R3: The displacement size code works as follows. 0 means no displacement. 1 means the low 8 bits, sign-extended. 2 means the full field: 32 bits wide, or the low 16 bits when narrow. 3 is illegal, sets `bad_form` and adds zero.
- R4: The width is wide when (`real_mode` ? 0 : `cs_dflt32`) XOR `asz_ovr` is 1, and narrow otherwise.
- R5: When the width is narrow, the sum wraps modulo 2^16 and bits 31:16 of `ea` are zero.
- R6: `bad_form` is set in these cases. In wide width, an index selector equal to 4 (the stack pointer). In narrow width, a base selector other than 3 or 5. In narrow width, an index selector other than 6 or 7. In narrow width, a present index with a non-zero scale code; the index is then used unscaled.
- R7: A request with both base and index present drops `req_ready` for the cycle after acceptance and returns `out_valid` two clocks after acceptance. A `req_valid` seen while `req_ready` is low is ignored and produces no result.
- R8: In real mode, an offset above 0xFFFF sets `gp_fault`.
- R9: In protected mode, an offset greater than `seg_limit` sets `gp_fault`.
- R10: `lin_addr` is `seg_base` + `ea` modulo 2^32. `out_valid` is raised for faulting results as well.
- R11: After reset `out_valid` is 0, `req_ready` is 1 and `ea`, `lin_addr`, `gp_fault` and `bad_form` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| use_base | input | 1 | Base term present |
| use_index | input | 1 | Index term present |
| scale_code | input | 2 | Index shift amount |
| disp_size | input | 2 | Displacement size code |
| base_sel | input | 3 | Base register number |
| index_sel | input | 3 | Index register number |
| base_val | input | 32 | Base register contents |
| index_val | input | 32 | Index register contents |
| disp_val | input | 32 | Displacement field |
| cs_dflt32 | input | 1 | Code segment default size, 1 = wide |
| asz_ovr | input | 1 | Address-size override for this operand |
| real_mode | input | 1 | Core is in real mode |
| seg_base | input | 32 | Selected segment base address |
| seg_limit | input | 32 | Selected segment limit |
| out_valid | output | 1 | Result valid for one clock |
| ea | output | 32 | Effective address |
| lin_addr | output | 32 | Linear address |
| gp_fault | output | 1 | Protection fault |
| bad_form | output | 1 | Illegal register or form choice |

## Verification
Some properties are checked on every clock by the assertions:
- the result latency of single-term and split requests;
- the one-cycle stall after a split request;
- the zero upper half of narrow results;
- that a result with no fault respects the real-mode ceiling or the segment limit it was checked against.

Other behaviour only the directed scenarios can show:
- the arithmetic itself: scaling, sign extension and narrow wrap-around;
- the width-selection truth table;
- the register legality rules;
- the carry-out wrap of the linear add;
- that a request offered during the stall leaves no trace at the outputs.

// File: rtl/ea_pkg.sv
package ea_pkg;
  parameter int AW = 32;
  parameter int SW = 3;

  localparam logic [1:0] DSZ_NONE = 2'd0;
  localparam logic [1:0] DSZ_BYTE = 2'd1;
  localparam logic [1:0] DSZ_FULL = 2'd2;

  typedef enum logic {ST_IDLE, ST_SECOND} ea_state_e;

  typedef struct packed {
    logic          use_base;
    logic          use_index;
    logic [1:0]    scale_code;
    logic [1:0]    disp_size;
    logic [SW-1:0] base_sel;
    logic [SW-1:0] index_sel;
    logic [AW-1:0] base_val;
    logic [AW-1:0] index_val;
    logic [AW-1:0] disp_val;
    logic          cs_dflt32;
    logic          asz_ovr;
    logic          real_mode;
    logic [AW-1:0] seg_base;
    logic [AW-1:0] seg_limit;
  } ea_req_t;
endpackage

// File: rtl/ea_size_ctl.sv
module ea_size_ctl #(
  parameter int SW      = 3,
  parameter int SP_CODE = 4,
  parameter int BX_CODE = 3,
  parameter int BP_CODE = 5,
  parameter int SI_CODE = 6,
  parameter int DI_CODE = 7
) (
  input  logic          cs_dflt32,
  input  logic          asz_ovr,
  input  logic          real_mode,
  input  logic          use_base,
  input  logic          use_index,
  input  logic [1:0]    scale_code,
  input  logic [1:0]    disp_size,
  input  logic [SW-1:0] base_sel,
  input  logic [SW-1:0] index_sel,
  output logic          wide,
  output logic          bad_form
);
  localparam logic [SW-1:0] SP = SW'(SP_CODE);
  localparam logic [SW-1:0] BX = SW'(BX_CODE);
  localparam logic [SW-1:0] BP = SW'(BP_CODE);
  localparam logic [SW-1:0] SI = SW'(SI_CODE);
  localparam logic [SW-1:0] DI = SW'(DI_CODE);

  logic dflt_wide;
  logic narrow_base_ok;
  logic narrow_index_ok;

  always_comb begin
    dflt_wide       = real_mode ? 1'b0 : cs_dflt32;
    wide            = dflt_wide ^ asz_ovr;
    narrow_base_ok  = (base_sel == BX) || (base_sel == BP);
    narrow_index_ok = (index_sel == SI) || (index_sel == DI);
    bad_form        = (disp_size == 2'd3);
    if (wide) begin
      if (use_index && (index_sel == SP)) bad_form = 1'b1;
    end else begin
      if (use_base && !narrow_base_ok)     bad_form = 1'b1;
      if (use_index && !narrow_index_ok)   bad_form = 1'b1;
      if (use_index && (scale_code != 2'd0)) bad_form = 1'b1;
    end
  end
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
  parameter int AW = 32,
  parameter int NW = 16
) (
  input  logic          wide,
  input  logic          use_base,
  input  logic          use_index,
  input  logic [1:0]    scale_code,
  input  logic [1:0]    disp_size,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [AW-1:0] disp_val,
  output logic [AW-1:0] ea
);
  logic [AW-1:0] disp_ext;
  logic [AW-1:0] base_term;
  logic [AW-1:0] index_term;
  logic [AW-1:0] raw_sum;

  always_comb begin
    case (disp_size)
      ea_pkg::DSZ_BYTE: disp_ext = {{(AW-8){disp_val[7]}}, disp_val[7:0]};
      ea_pkg::DSZ_FULL: disp_ext = disp_val;
      default:          disp_ext = '0;
    endcase
    base_term  = use_base ? base_val : '0;
    index_term = use_index ? index_val : '0;
    if (wide) index_term = index_term << scale_code;
    raw_sum = base_term + index_term + disp_ext;
  end

  generate
    if (AW > NW) begin : g_mask
      assign ea = wide ? raw_sum : {{(AW-NW){1'b0}}, raw_sum[NW-1:0]};
    end else begin : g_flat
      assign ea = raw_sum;
    end
  endgenerate
endmodule

// File: rtl/ea_seg_check.sv
module ea_seg_check #(
  parameter int AW = 32,
  parameter int NW = 16
) (
  input  logic [AW-1:0] ea,
  input  logic          real_mode,
  input  logic [AW-1:0] seg_base,
  input  logic [AW-1:0] seg_limit,
  output logic [AW-1:0] lin_addr,
  output logic          gp_fault
);
  logic over_real;
  logic over_limit;

  generate
    if (AW > NW) begin : g_hi
      assign over_real = |ea[AW-1:NW];
    end else begin : g_nohi
      assign over_real = 1'b0;
    end
  endgenerate

  always_comb begin
    over_limit = ea > seg_limit;
    gp_fault   = real_mode ? over_real : over_limit;
    lin_addr   = seg_base + ea;
  end
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen #(
  parameter int AW = ea_pkg::AW,
  parameter int SW = ea_pkg::SW,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          use_base,
  input  logic          use_index,
  input  logic [1:0]    scale_code,
  input  logic [1:0]    disp_size,
  input  logic [SW-1:0] base_sel,
  input  logic [SW-1:0] index_sel,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [AW-1:0] disp_val,
  input  logic          cs_dflt32,
  input  logic          asz_ovr,
  input  logic          real_mode,
  input  logic [AW-1:0] seg_base,
  input  logic [AW-1:0] seg_limit,
  output logic          out_valid,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] lin_addr,
  output logic          gp_fault,
  output logic          bad_form
);
  import ea_pkg::*;

  ea_state_e     state;
  ea_req_t       live_req;
  ea_req_t       hold_req;
  ea_req_t       src;
  logic          fire;
  logic          split;
  logic          c_wide;
  logic          c_bad;
  logic [AW-1:0] c_ea;
  logic [AW-1:0] c_lin;
  logic          c_fault;

  logic          valid_q;
  logic [AW-1:0] ea_q;
  logic [AW-1:0] lin_q;
  logic          fault_q;
  logic          bad_q;
  logic          wide_q;
  logic          real_q;
  logic [AW-1:0] limit_q;

  always_comb begin
    live_req.use_base   = use_base;
    live_req.use_index  = use_index;
    live_req.scale_code = scale_code;
    live_req.disp_size  = disp_size;
    live_req.base_sel   = base_sel;
    live_req.index_sel  = index_sel;
    live_req.base_val   = base_val;
    live_req.index_val  = index_val;
    live_req.disp_val   = disp_val;
    live_req.cs_dflt32  = cs_dflt32;
    live_req.asz_ovr    = asz_ovr;
    live_req.real_mode  = real_mode;
    live_req.seg_base   = seg_base;
    live_req.seg_limit  = seg_limit;
  end

  assign req_ready = (state == ST_IDLE);
  assign fire      = req_valid && req_ready;
  assign split     = use_base && use_index;
  assign src       = (state == ST_SECOND) ? hold_req : live_req;

  ea_size_ctl #(.SW(SW)) u_size (
    .cs_dflt32 (src.cs_dflt32),
    .asz_ovr   (src.asz_ovr),
    .real_mode (src.real_mode),
    .use_base  (src.use_base),
    .use_index (src.use_index),
    .scale_code(src.scale_code),
    .disp_size (src.disp_size),
    .base_sel  (src.base_sel),
    .index_sel (src.index_sel),
    .wide      (c_wide),
    .bad_form  (c_bad)
  );

  ea_adder #(.AW(AW), .NW(NW)) u_add (
    .wide      (c_wide),
    .use_base  (src.use_base),
    .use_index (src.use_index),
    .scale_code(src.scale_code),
    .disp_size (src.disp_size),
    .base_val  (src.base_val),
    .index_val (src.index_val),
    .disp_val  (src.disp_val),
    .ea        (c_ea)
  );

  ea_seg_check #(.AW(AW), .NW(NW)) u_seg (
    .ea        (c_ea),
    .real_mode (src.real_mode),
    .seg_base  (src.seg_base),
    .seg_limit (src.seg_limit),
    .lin_addr  (c_lin),
    .gp_fault  (c_fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      hold_req <= '0;
      valid_q  <= 1'b0;
      ea_q     <= '0;
      lin_q    <= '0;
      fault_q  <= 1'b0;
      bad_q    <= 1'b0;
      wide_q   <= 1'b0;
      real_q   <= 1'b0;
      limit_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if ((state == ST_SECOND) || (fire && !split)) begin
        valid_q <= 1'b1;
        ea_q    <= c_ea;
        lin_q   <= c_lin;
        fault_q <= c_fault;
        bad_q   <= c_bad;
        wide_q  <= c_wide;
        real_q  <= src.real_mode;
        limit_q <= src.seg_limit;
      end
      if (state == ST_SECOND) begin
        state <= ST_IDLE;
      end else if (fire && split) begin
        hold_req <= live_req;
        state    <= ST_SECOND;
      end
    end
  end

  assign out_valid = valid_q;
  assign ea        = ea_q;
  assign lin_addr  = lin_q;
  assign gp_fault  = fault_q;
  assign bad_form  = bad_q;

  AST_SINGLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !(use_base && use_index)) |=> out_valid); // R1

  AST_SPLIT_STALL: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && use_base && use_index) |=> (!out_valid && !req_ready)); // R7

  AST_SPLIT_DONE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && use_base && use_index) |-> ##2 (out_valid && req_ready)); // R7

  AST_NARROW_WRAP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !wide_q) |-> (ea[AW-1:NW] == '0)); // R5

  AST_REAL_CEILING: assert property (@(posedge clk) disable iff (rst)
    (out_valid && real_q && !gp_fault) |-> (ea[AW-1:NW] == '0)); // R8

  AST_LIMIT_RESPECTED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !real_q && !gp_fault) |-> (ea <= limit_q)); // R9
endmodule

// File: tb/seg_ea_gen_bench.sv
module seg_ea_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic req_valid = 0, use_base = 0, use_index = 0;
  logic [1:0] scale_code = 0, disp_size = 0;
  logic [2:0] base_sel = 0, index_sel = 0;
  logic [31:0] base_val = 0, index_val = 0, disp_val = 0;
  logic cs_dflt32 = 1, asz_ovr = 0, real_mode = 0;
  logic [31:0] seg_base = 0, seg_limit = 32'hFFFF_FFFF;
  logic req_ready, out_valid, gp_fault, bad_form;
  logic [31:0] ea, lin_addr;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  seg_ea_gen u_seg_ea_gen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .use_base(use_base), .use_index(use_index), .scale_code(scale_code),
    .disp_size(disp_size), .base_sel(base_sel), .index_sel(index_sel),
    .base_val(base_val), .index_val(index_val), .disp_val(disp_val),
    .cs_dflt32(cs_dflt32), .asz_ovr(asz_ovr), .real_mode(real_mode),
    .seg_base(seg_base), .seg_limit(seg_limit), .out_valid(out_valid),
    .ea(ea), .lin_addr(lin_addr), .gp_fault(gp_fault), .bad_form(bad_form)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic setreq(input logic hb, input logic hi, input logic [1:0] sc, input logic [1:0] ds,
                        input logic [2:0] bs, input logic [2:0] is, input logic [31:0] bv,
                        input logic [31:0] iv, input logic [31:0] dp);
    use_base = hb; use_index = hi; scale_code = sc; disp_size = ds;
    base_sel = bs; index_sel = is; base_val = bv; index_val = iv; disp_val = dp;
  endtask

  task automatic setmode(input logic db, input logic ov, input logic rm, input logic [31:0] sb, input logic [31:0] sl);
    cs_dflt32 = db; asz_ovr = ov; real_mode = rm; seg_base = sb; seg_limit = sl;
  endtask

  task automatic model(output logic [31:0] e, output logic [31:0] l, output logic f, output logic b);
    logic w;
    logic [31:0] dx, ix;
    w  = (real_mode ? 1'b0 : cs_dflt32) ^ asz_ovr;
    dx = (disp_size == 2'd1) ? {{24{disp_val[7]}}, disp_val[7:0]} :
         (disp_size == 2'd2) ? disp_val : 32'd0;
    ix = use_index ? index_val : 32'd0;
    if (w) ix = ix * (32'd1 << scale_code);
    e = (use_base ? base_val : 32'd0) + ix + dx;
    if (!w) e = e & 32'h0000_FFFF;
    f = real_mode ? (e > 32'h0000_FFFF) : (e > seg_limit);
    l = seg_base + e;
    if (w) b = (use_index && index_sel == 3'd4);
    else   b = (use_base && !(base_sel == 3'd3 || base_sel == 3'd5)) ||
               (use_index && !(index_sel == 3'd6 || index_sel == 3'd7)) ||
               (use_index && scale_code != 2'd0);
    if (disp_size == 2'd3) b = 1'b1;
  endtask

  task automatic issue(input string tag);
    logic [31:0] xe, xl;
    logic xf, xb;
    bit both;
    model(xe, xl, xf, xb);
    both = use_base && use_index;
    @(negedge clk);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (both) begin
      check("R7", "stall valid", {31'd0, out_valid}, 32'd0);
      check("R7", "stall ready", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
    end
    check(tag, "valid", {31'd0, out_valid}, 32'd1);
    check(tag, "ea", ea, xe);
    check(tag, "lin", lin_addr, xl);
    check(tag, "fault", {31'd0, gp_fault}, {31'd0, xf});
    check(tag, "bad", {31'd0, bad_form}, {31'd0, xb});
  endtask

  task automatic t_reset;
    check("R11", "valid", {31'd0, out_valid}, 32'd0);
    check("R11", "ready", {31'd0, req_ready}, 32'd1);
    check("R11", "ea", ea, 32'd0);
    check("R11", "lin", lin_addr, 32'd0);
    check("R11", "flags", {30'd0, gp_fault, bad_form}, 32'd0);
  endtask

  task automatic t_terms;
    setmode(1, 0, 0, 32'h1000_0000, 32'hFFFF_FFFF);
    setreq(0, 0, 0, 2, 0, 0, 0, 0, 32'h1234_5678); issue("R1");
    check("R1", "direct ea", ea, 32'h1234_5678);
    setreq(1, 0, 0, 0, 0, 0, 32'h400, 0, 32'hDEAD_BEEF); issue("R1");
    check("R1", "indirect ea", ea, 32'h400);
    setreq(1, 0, 0, 1, 1, 0, 32'h400, 0, 32'h18); issue("R1");
  endtask

  task automatic t_scale;
    setmode(1, 0, 0, 0, 32'hFFFF_FFFF);
    for (int s = 0; s < 4; s++) begin
      setreq(0, 1, 2'(s), 2, 0, 2, 0, 32'h100, 32'h10); issue("R2");
      check("R2", "scaled ea", ea, 32'h10 + (32'h100 << s));
    end
  endtask

  task automatic t_disp;
    setmode(1, 0, 0, 0, 32'hFFFF_FFFF);
    setreq(1, 0, 0, 1, 0, 0, 32'h1000, 0, 32'h0000_00F0); issue("R3");
    check("R3", "neg byte", ea, 32'h0000_0FF0);
    setreq(1, 0, 0, 2, 0, 0, 32'h1000, 0, 32'hFFFF_FFF0); issue("R3");
    setreq(1, 0, 0, 3, 0, 0, 32'h1000, 0, 32'h55); issue("R3");
    check("R3", "illegal size", {31'd0, bad_form}, 32'd1);
  endtask

  task automatic t_size;
    setreq(1, 0, 0, 0, 3, 0, 32'h0001_2345, 0, 0);
    setmode(1, 0, 1, 0, 32'hFFFF_FFFF); issue("R4");
    check("R4", "real default narrow", ea, 32'h2345);
    setmode(0, 0, 0, 0, 32'hFFFF_FFFF); issue("R4");
    check("R4", "d0 narrow", ea, 32'h2345);
    setmode(0, 1, 0, 0, 32'hFFFF_FFFF); issue("R4");
    check("R4", "d0 ovr wide", ea, 32'h0001_2345);
    setmode(1, 1, 0, 0, 32'hFFFF_FFFF); issue("R4");
    check("R4", "d1 ovr narrow", ea, 32'h2345);
  endtask

  task automatic t_narrow;
    setmode(0, 0, 0, 32'h100, 32'hFFFF_FFFF);
    setreq(1, 1, 0, 2, 3, 6, 32'hFFF0, 32'h20, 32'h0001_0005); issue("R5");
    check("R5", "wrap ea", ea, 32'h0015);
    setreq(1, 0, 0, 1, 5, 0, 32'h0010, 0, 32'h80); issue("R5");
    check("R5", "byte wrap", ea, 32'hFF90);
  endtask

  task automatic t_legal;
    setmode(1, 0, 0, 0, 32'hFFFF_FFFF);
    setreq(0, 1, 0, 0, 0, 4, 0, 32'h40, 0); issue("R6");
    check("R6", "sp index", {31'd0, bad_form}, 32'd1);
    setreq(1, 0, 0, 0, 4, 0, 32'h40, 0, 0); issue("R6");
    check("R6", "sp base ok", {31'd0, bad_form}, 32'd0);
    setmode(0, 0, 0, 0, 32'hFFFF_FFFF);
    setreq(1, 0, 0, 0, 0, 0, 32'h40, 0, 0); issue("R6");
    setreq(0, 1, 2, 0, 0, 7, 0, 32'h40, 0); issue("R6");
    check("R6", "narrow unscaled", ea, 32'h40);
    setreq(0, 1, 0, 0, 0, 3, 0, 32'h40, 0); issue("R6");
  endtask

  task automatic t_split_ignore;
    logic [31:0] xe, xl;
    logic xf, xb;
    setmode(1, 0, 0, 32'h2000, 32'hFFFF_FFFF);
    setreq(1, 1, 3, 1, 0, 1, 32'h1000, 32'h10, 32'hFF);
    model(xe, xl, xf, xb);
    @(negedge clk);
    req_valid = 1;
    @(negedge clk);
    setreq(0, 0, 0, 2, 0, 0, 0, 0, 32'hABCD);
    check("R7", "ready low", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    req_valid = 0;
    check("R7", "split valid", {31'd0, out_valid}, 32'd1);
    check("R7", "split ea", ea, xe);
    check("R7", "split ea value", ea, 32'h107F);
    check("R7", "split lin", lin_addr, xl);
    @(negedge clk);
    check("R7", "ignored request", {31'd0, out_valid}, 32'd0);
    check("R7", "ea kept", ea, 32'h107F);
  endtask

  task automatic t_real_fault;
    setmode(0, 1, 1, 32'h5_0000, 32'h0);
    setreq(1, 0, 0, 0, 3, 0, 32'h0001_0000, 0, 0); issue("R8");
    check("R8", "over ffff", {31'd0, gp_fault}, 32'd1);
    setreq(1, 0, 0, 0, 3, 0, 32'h0000_FFFF, 0, 0); issue("R8");
    check("R8", "at ffff", {31'd0, gp_fault}, 32'd0);
  endtask

  task automatic t_limit;
    setmode(1, 0, 0, 0, 32'hFFF);
    setreq(0, 0, 0, 2, 0, 0, 0, 0, 32'h1000); issue("R9");
    check("R9", "over limit", {31'd0, gp_fault}, 32'd1);
    check("R10", "fault still valid", {31'd0, out_valid}, 32'd1);
    setreq(0, 0, 0, 2, 0, 0, 0, 0, 32'hFFF); issue("R9");
    check("R9", "at limit", {31'd0, gp_fault}, 32'd0);
  endtask

  task automatic t_lin;
    setmode(1, 0, 0, 32'hFFFF_F000, 32'hFFFF_FFFF);
    setreq(1, 0, 0, 0, 2, 0, 32'h2000, 0, 0); issue("R10");
    check("R10", "lin wrap", lin_addr, 32'h0000_1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_terms();
    t_scale();
    t_disp();
    t_size();
    t_narrow();
    t_legal();
    t_split_ignore();
    t_real_fault();
    t_limit();
    t_lin();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule